// File: doc/BRIEF.md
# Two-Level Interrupt Control Register

This block is the central interrupt control and status byte of a small microcontroller. It captures events from three core sources: a timer rollover, an external edge and a pin-change detector. It holds one enable per core source, an enable for the peripheral group and a master gate. From these it forms the single interrupt request that goes to the CPU.

Software reaches the byte over a simple register bus: a select, a write strobe and 8-bit write and read data. The timer and external sources deliver one-cycle pulses, and the block latches each pulse into a sticky flag. The pin-change bit is not stored here. It reflects the detector's pending level directly. The peripheral group arrives as one summary level. That level only reaches the request when the group enable is set, and the request then passes through the master gate.

Top module: `irq_ctl_reg`

## Requirements
- R1: Register image bit positions, MSB first: bit 7 master gate, bit 6 peripheral-group enable, bit 5 timer enable, bit 4 external enable, bit 3 pin-change enable, bit 2 timer flag, bit 1 external flag, bit 0 pin-change flag.
- R2: While reset is asserted, bits 7..1 read 0 and the request is 0.
- R3: A pulse on `ev_tick_ovf` sets bit 2, and a pulse on `ev_ext_edge` sets bit 1, at the next clock edge. This happens whatever the values of the enables and the master gate.
- R4: Bits 2 and 1 hold their value until a register write changes them. A write with 0 in the bit clears it. A write with 1 in the bit sets it.
- R5: Bit 0 always equals `chg_pending`, and writes have no effect on it.
- R6: When bit 7 is 0, `irq_req` is 0.
- R7: `periph_pending` contributes to `irq_req` only when both bit 6 and bit 7 are 1.
- R8: `irq_req` equals bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND periph_pending)).
- R9: If a source pulse and a write of 0 to the same flag fall in the same cycle, the flag ends up 1.
- R10: `bus_rdata` shows the image combinationally while `bus_sel` is 1 and reads 0 otherwise. A write needs both `bus_sel` and `bus_wr`, and it takes effect at the next clock edge.
- R11: A flag latched while its enables were 0 raises `irq_req` in the first cycle after a write turns those enables on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, valid when selected |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ev_tick_ovf | input | 1 | Timer rollover pulse, one cycle |
| ev_ext_edge | input | 1 | External edge pulse, one cycle |
| chg_pending | input | 1 | Pin-change detector pending level |
| periph_pending | input | 1 | Summary level of pending peripheral interrupts |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
A hardware flag-set pulse and a software write to the same flag can land on the same clock edge. The bench provokes this by raising `ev_tick_ovf` on the same half-cycle in which it drives a write with 0 in bit 2. It judges the result by reading bit 2 after that edge, where 1 is the only accepted value. The bench also lines up a write that turns on the enables with a flag that is already pending. The request must then rise in the very first cycle after that write.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int IMG_W      = 8;
  localparam int NUM_STICKY = 2;
  localparam int BIT_GATE   = 7;
  localparam int BIT_GRP    = 6;
  localparam int BIT_TMR_EN = 5;
  localparam int BIT_EXT_EN = 4;
  localparam int BIT_CHG_EN = 3;
  localparam int BIT_TMR_F  = 2;
  localparam int BIT_EXT_F  = 1;
  localparam int BIT_CHG_F  = 0;
  localparam int STICKY_LSB = BIT_EXT_F;
  localparam int EN_LSB     = BIT_CHG_EN;
  localparam int EN_W       = IMG_W - EN_LSB;

  typedef struct packed {
    logic gate_all;
    logic grp_en;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
  } en_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_ok_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wval_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // hardware set has priority over a software clear
  always_comb begin
    flag_d = flag_q;
    if (wr_i) flag_d = wval_i;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) flag_q <= 1'b0;
    else           flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_ok_n,
  input  logic wr_i,
  input  en_t  wval_i,
  output en_t  en_o
);
  en_t en_q;
  en_t en_d;

  always_comb begin
    en_d = wr_i ? wval_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_ctl_pkg::*;
(
  input  en_t  en_i,
  input  logic tmr_f_i,
  input  logic ext_f_i,
  input  logic chg_f_i,
  input  logic periph_i,
  output logic req_o
);
  logic core_any;
  logic grp_any;

  always_comb begin
    core_any = (en_i.tmr_en & tmr_f_i) | (en_i.ext_en & ext_f_i) | (en_i.chg_en & chg_f_i);
    grp_any  = en_i.grp_en & periph_i;
    req_o    = en_i.gate_all & (core_any | grp_any);
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IMG_W-1:0] bus_wdata,
  output logic [IMG_W-1:0] bus_rdata,
  input  logic             ev_tick_ovf,
  input  logic             ev_ext_edge,
  input  logic             chg_pending,
  input  logic             periph_pending,
  output logic             irq_req
);
  logic                  rst_ok_n;
  logic                  wr_hit;
  en_t                   en_q;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_q;
  logic [IMG_W-1:0]      ctl_img;
  logic                  unused_wbit0;

  assign wr_hit       = bus_sel & bus_wr;
  assign unused_wbit0 = bus_wdata[BIT_CHG_F];
  assign sticky_set   = {ev_tick_ovf, ev_ext_edge};

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n)
  );

  irq_enable_bank u_en (
    .clk(clk), .rst_ok_n(rst_ok_n), .wr_i(wr_hit),
    .wval_i(en_t'(bus_wdata[IMG_W-1:EN_LSB])), .en_o(en_q)
  );

  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
    irq_sticky_flag u_flag (
      .clk(clk), .rst_ok_n(rst_ok_n), .set_i(sticky_set[gi]),
      .wr_i(wr_hit), .wval_i(bus_wdata[STICKY_LSB+gi]), .flag_o(sticky_q[gi])
    );
  end

  assign ctl_img = {en_q, sticky_q, chg_pending};

  irq_req_gate u_gate (
    .en_i(en_q), .tmr_f_i(ctl_img[BIT_TMR_F]), .ext_f_i(ctl_img[BIT_EXT_F]),
    .chg_f_i(ctl_img[BIT_CHG_F]), .periph_i(periph_pending), .req_o(irq_req)
  );

  assign bus_rdata = bus_sel ? ctl_img : '0;
endmodule

// File: rtl/irq_ctl_reg_chk.sv
module irq_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_ok_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] ctl_img,
  input logic       ev_tick_ovf,
  input logic       ev_ext_edge,
  input logic       chg_pending,
  input logic       periph_pending,
  input logic       irq_req
);
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_clear_r2: assert (ctl_img[7:1] == 7'd0 && (irq_req == 1'b0 || ctl_img[7] == 1'b0));
    end
  end

  p_tmr_set_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_tick_ovf |=> ctl_img[2]);

  p_ext_set_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ev_ext_edge |=> ctl_img[1]);

  p_tmr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ctl_img[2] && !(bus_sel && bus_wr)) |=> ctl_img[2]);

  p_chg_mirror_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ctl_img[0] == chg_pending);

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !ctl_img[7] |-> !irq_req);

  p_grp_mask_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (periph_pending && !ctl_img[6] && ctl_img[5:3] == 3'b000) |-> !irq_req);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ev_tick_ovf && bus_sel && bus_wr && !bus_wdata[2]) |=> ctl_img[2]);
endmodule

bind irq_ctl_reg irq_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ctl_img(ctl_img),
  .ev_tick_ovf(ev_tick_ovf), .ev_ext_edge(ev_ext_edge),
  .chg_pending(chg_pending), .periph_pending(periph_pending), .irq_req(irq_req)
);

// File: tb/test_irq_ctl_reg.sv
module test_irq_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ev_tick_ovf, ev_ext_edge, chg_pending, periph_pending;
  logic       irq_req;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_ctl_reg i_irq_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_tick_ovf(ev_tick_ovf),
    .ev_ext_edge(ev_ext_edge), .chg_pending(chg_pending),
    .periph_pending(periph_pending), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_img(output logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic wr_img(input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic pulse(input bit tmr, input bit ext);
    @(negedge clk);
    ev_tick_ovf = tmr; ev_ext_edge = ext;
    @(negedge clk);
    ev_tick_ovf = 1'b0; ev_ext_edge = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    wr_img(8'hFE);
    @(negedge clk);
    rst_n = 1'b0;
    #2 rd_img(v);
    chk("R2 image in reset", v, 8'h00);
    chk("R2 irq in reset", {7'd0, irq_req}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_img(v);
    chk("R2 image after reset", v, 8'h00);
    bus_sel = 1'b0;
  endtask

  task automatic t_layout();
    logic [7:0] v;
    wr_img(8'hA4);
    rd_img(v);
    chk("R1 layout write A4", v, 8'hA4);
    wr_img(8'h5A);
    rd_img(v);
    chk("R1 layout write 5A", v, 8'h5A);
    bus_sel = 1'b0;
    wr_img(8'h00);
  endtask

  task automatic t_latch_disabled();
    logic [7:0] v;
    pulse(1'b1, 1'b0);
    rd_img(v);
    chk("R3 timer flag with all enables off", v, 8'h04);
    chk("R3 no irq", {7'd0, irq_req}, 8'h00);
    pulse(1'b0, 1'b1);
    rd_img(v);
    chk("R3 external flag with enables off", v, 8'h06);
    wr_img(8'hA6);
    #1 chk("R11 irq right after enabling", {7'd0, irq_req}, 8'h01);
    wr_img(8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    pulse(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rd_img(v);
    chk("R4 flags hold", v, 8'h06);
    wr_img(8'h04);
    rd_img(v);
    chk("R4 clear external only", v, 8'h04);
    wr_img(8'h00);
    rd_img(v);
    chk("R4 clear timer", v, 8'h00);
    wr_img(8'h02);
    rd_img(v);
    chk("R4 software set", v, 8'h02);
    wr_img(8'h00);
  endtask

  task automatic t_chg();
    logic [7:0] v;
    wr_img(8'h01);
    rd_img(v);
    chk("R5 write 1 ignored", v, 8'h00);
    chg_pending = 1'b1;
    rd_img(v);
    chk("R5 mirror high", v, 8'h01);
    wr_img(8'h00);
    rd_img(v);
    chk("R5 write 0 ignored", v, 8'h01);
    wr_img(8'h88);
    #1 chk("R8 pin-change path", {7'd0, irq_req}, 8'h01);
    chg_pending = 1'b0;
    #1 chk("R8 pin-change drops", {7'd0, irq_req}, 8'h00);
    wr_img(8'h00);
  endtask

  task automatic t_gate();
    wr_img(8'h7A);
    pulse(1'b1, 1'b1);
    #1 chk("R6 gate off blocks", {7'd0, irq_req}, 8'h00);
    wr_img(8'hA6);
    #1 chk("R8 timer path", {7'd0, irq_req}, 8'h01);
    wr_img(8'h92);
    #1 chk("R8 external path", {7'd0, irq_req}, 8'h01);
    wr_img(8'h84);
    #1 chk("R8 flag without enable", {7'd0, irq_req}, 8'h00);
    wr_img(8'h00);
  endtask

  task automatic t_periph();
    periph_pending = 1'b1;
    wr_img(8'h80);
    #1 chk("R7 group enable off", {7'd0, irq_req}, 8'h00);
    wr_img(8'hC0);
    #1 chk("R7 group path", {7'd0, irq_req}, 8'h01);
    wr_img(8'h40);
    #1 chk("R7 gate off", {7'd0, irq_req}, 8'h00);
    periph_pending = 1'b0;
    wr_img(8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00; ev_tick_ovf = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_tick_ovf = 1'b0;
    rd_img(v);
    chk("R9 set beats write 0", v, 8'h04);
    bus_sel = 1'b0;
    wr_img(8'h00);
  endtask

  task automatic t_bus();
    logic [7:0] v;
    wr_img(8'hF8);
    bus_sel = 1'b0;
    #1 chk("R10 unselected read", bus_rdata, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_img(v);
    chk("R10 write without select ignored", v, 8'hF8);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h08;
    #1 chk("R10 write not yet visible", bus_rdata, 8'hF8);
    @(negedge clk);
    bus_wr = 1'b0;
    rd_img(v);
    chk("R10 write visible after edge", v, 8'h08);
    bus_sel = 1'b0;
    wr_img(8'h00);
  endtask

  initial begin
    rst_n = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    ev_tick_ovf = 1'b0; ev_ext_edge = 1'b0; chg_pending = 1'b0; periph_pending = 1'b0;
    do_reset();
    t_reset();
    t_layout();
    t_latch_disabled();
    t_sticky();
    t_chg();
    t_gate();
    t_periph();
    t_collision();
    t_bus();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule